// File: doc/BRIEF.md
# Refill-Snooping Lookup Metadata Queue

This block is a small first-in first-out queue that carries cache lookup results from a prefetch stage to the main fetch pipeline. Each entry describes two cache lines. For each line it stores the set index, the way, the tag and a hit flag. The lookup that produced an entry may be out of date by the time the entry is consumed, because the cache can be refilled while the entry waits in the queue.

To keep the flags correct, the queue watches a refill broadcast on every cycle. The broadcast gives the set, way and tag being written. Every occupied entry compares itself with the broadcast in parallel and rewrites its hit flags in place:
- A stored miss whose line is now being written becomes a hit in the refilled way.
- A stored hit whose way is overwritten by a different line becomes a miss.

Dequeue is frozen in every refill cycle, whether or not the refill matches anything. Enqueue is also refused in every refill cycle. As a result, an entry is never written and corrected in the same cycle, and the consumer only ever sees corrected flags.

Top module: `snoop_meta_fifo`

## Requirements
- R1: After reset the queue is empty: `empty` is 1, `full` is 0 and `deq_valid` is 0.
- R2: Entries leave in the order they were accepted. The `deq_*` outputs show the oldest entry, and a cycle with `deq_valid` and `deq_ready` both high removes it.
- R3: After DEPTH (8) accepted enqueues, `full` is 1. An enqueue offered while full is dropped and leaves the stored entries unchanged.
- R4: `deq_valid` is 0 whenever the queue is empty.
- R5: A stored miss becomes a hit when a refill has the same set and the same tag. Its way becomes the refill way.
- R6: A stored hit becomes a miss when a refill has the same set and the same way but a different tag. Its way is kept.
- R7: A refill that matches neither case leaves a line's hit flag and way unchanged. Cases that fall here include a different set, a hit line rewritten with its own tag, and a hit line in another way.
- R8: `deq_valid` is 0 in every cycle where `refill_valid` is 1, and no entry is removed in that cycle.
- R9: An enqueue offered in a cycle where `refill_valid` is 1 is dropped.
- R10: `flush` empties the queue in one cycle and resets both pointers. An enqueue offered in the same cycle is dropped.
- R11: The two lines of an entry are compared and corrected independently. Line 0 uses bits [SET_W-1:0], [WAY_W-1:0] and [TAG_W-1:0] of the packed fields, and line 1 uses the next slice up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all entries |
| enq_valid | input | 1 | Offer an entry |
| enq_set | input | LINES*SET_W (12) | Set index per line, line 0 in the low slice |
| enq_way | input | LINES*WAY_W (4) | Way per line |
| enq_tag | input | LINES*TAG_W (40) | Tag per line |
| enq_hit | input | LINES (2) | Hit flag per line |
| full | output | 1 | No free entry |
| empty | output | 1 | No stored entry |
| deq_ready | input | 1 | Consumer takes the head entry |
| deq_valid | output | 1 | Head entry is available |
| deq_set | output | LINES*SET_W (12) | Head set index per line |
| deq_way | output | LINES*WAY_W (4) | Head way per line, after correction |
| deq_tag | output | LINES*TAG_W (40) | Head tag per line |
| deq_hit | output | LINES (2) | Head hit flag per line, after correction |
| refill_valid | input | 1 | A refill writes the cache this cycle |
| refill_set | input | SET_W (6) | Set being refilled |
| refill_way | input | WAY_W (2) | Way being refilled |
| refill_tag | input | TAG_W (20) | Tag being written |

## Verification
The correction properties assume two things:
- A line's stored fields change only through a load or a refill comparison.
- A load and a refill never coincide for an entry, because the queue refuses enqueue while `refill_valid` is high.

The stimulus keeps the refill broadcast idle on load cycles in the vector walk. It raises `refill_valid` together with `enq_valid` only in the directed test that checks such an enqueue is dropped.

The bench also assumes the consumer observes the head only after the refill cycle has ended. It therefore samples `deq_*` in the first idle cycle after each refill.

// File: rtl/snoop_meta_pkg.sv
package snoop_meta_pkg;

   // Correction applied to one stored line by a refill broadcast
   typedef enum logic [1:0] {
      UPD_NONE  = 2'd0,
      UPD_FILL  = 2'd1,
      UPD_EVICT = 2'd2
   } upd_e;

   // Decide how a refill affects a stored line, given its hit state and
   // the outcome of the set, way and tag comparisons.
   function automatic upd_e classify(input logic hit,
                                     input logic set_eq,
                                     input logic way_eq,
                                     input logic tag_eq);
      upd_e r;
      r = UPD_NONE;
      if (set_eq) begin
         if (!hit && tag_eq)
            r = UPD_FILL;
         else if (hit && way_eq && !tag_eq)
            r = UPD_EVICT;
      end
      return r;
   endfunction

endpackage

// File: rtl/snoop_meta_line.sv
module snoop_meta_line
   import snoop_meta_pkg::*;
#(
   parameter int SET_W = 6,
   parameter int WAY_W = 2,
   parameter int TAG_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             live,
   input  logic             load,
   input  logic [SET_W-1:0] ld_set,
   input  logic [WAY_W-1:0] ld_way,
   input  logic [TAG_W-1:0] ld_tag,
   input  logic             ld_hit,
   input  logic             rf_valid,
   input  logic [SET_W-1:0] rf_set,
   input  logic [WAY_W-1:0] rf_way,
   input  logic [TAG_W-1:0] rf_tag,
   output logic [SET_W-1:0] set_q,
   output logic [WAY_W-1:0] way_q,
   output logic [TAG_W-1:0] tag_q,
   output logic             hit_q
);

   upd_e act;
   logic set_eq, way_eq, tag_eq;

   assign set_eq = (rf_set == set_q);
   assign way_eq = (rf_way == way_q);
   assign tag_eq = (rf_tag == tag_q);

   always_comb begin
      act = UPD_NONE;
      if (live && rf_valid)
         act = classify(hit_q, set_eq, way_eq, tag_eq);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_q <= '0;
         way_q <= '0;
         tag_q <= '0;
         hit_q <= 1'b0;
      end else if (load) begin
         set_q <= ld_set;
         way_q <= ld_way;
         tag_q <= ld_tag;
         hit_q <= ld_hit;
      end else begin
         case (act)
            UPD_FILL: begin
               hit_q <= 1'b1;
               way_q <= rf_way;
            end
            UPD_EVICT: hit_q <= 1'b0;
            default: ;
         endcase
      end
   end

   // R5
   fill_to_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && rf_valid && !load && !hit_q && rf_set == set_q && rf_tag == tag_q)
      |=> (hit_q && way_q == $past(rf_way)));

   // R6
   evict_to_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && rf_valid && !load && hit_q && rf_set == set_q &&
       rf_way == way_q && rf_tag != tag_q)
      |=> !hit_q);

   // R7
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rf_valid && !load) |=> ($stable(hit_q) && $stable(way_q)));

endmodule

// File: rtl/snoop_meta_ptrs.sv
module snoop_meta_ptrs #(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] wr_idx,
   output logic [AW-1:0] rd_idx,
   output logic [DEPTH-1:0] live,
   output logic          full,
   output logic          empty
);

   logic [AW-1:0] wr_q, rd_q;
   logic [AW:0]   cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: ;
         endcase
      end
   end

   assign wr_idx = wr_q;
   assign rd_idx = rd_q;
   assign full   = (cnt_q == (AW+1)'(DEPTH));
   assign empty  = (cnt_q == '0);

   for (genvar e = 0; e < DEPTH; e++) begin : g_live
      logic [AW-1:0] off;
      assign off     = AW'(e) - rd_q;
      assign live[e] = ({1'b0, off} < cnt_q);
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);

   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);

   // R10
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0 && wr_q == '0 && rd_q == '0));

   // R1
   excl_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

endmodule

// File: rtl/snoop_meta_fifo.sv
module snoop_meta_fifo #(
   parameter int DEPTH = 8,
   parameter int LINES = 2,
   parameter int SET_W = 6,
   parameter int WAY_W = 2,
   parameter int TAG_W = 20
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   enq_valid,
   input  logic [LINES*SET_W-1:0] enq_set,
   input  logic [LINES*WAY_W-1:0] enq_way,
   input  logic [LINES*TAG_W-1:0] enq_tag,
   input  logic [LINES-1:0]       enq_hit,
   output logic                   full,
   output logic                   empty,
   input  logic                   deq_ready,
   output logic                   deq_valid,
   output logic [LINES*SET_W-1:0] deq_set,
   output logic [LINES*WAY_W-1:0] deq_way,
   output logic [LINES*TAG_W-1:0] deq_tag,
   output logic [LINES-1:0]       deq_hit,
   input  logic                   refill_valid,
   input  logic [SET_W-1:0]       refill_set,
   input  logic [WAY_W-1:0]       refill_way,
   input  logic [TAG_W-1:0]       refill_tag
);

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("snoop_meta_fifo: DEPTH must be a power of two of at least 2");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("snoop_meta_fifo: LINES must be at least 1");
   end
   if (SET_W < 1 || WAY_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("snoop_meta_fifo: field widths must be positive");
   end

   logic          push, pop;
   logic [AW-1:0] wr_idx, rd_idx;
   logic [DEPTH-1:0] live;

   logic [SET_W-1:0] set_a [DEPTH][LINES];
   logic [WAY_W-1:0] way_a [DEPTH][LINES];
   logic [TAG_W-1:0] tag_a [DEPTH][LINES];
   logic             hit_a [DEPTH][LINES];

   // Both ends freeze while a refill is broadcast
   assign push      = enq_valid && !full && !refill_valid && !flush;
   assign deq_valid = !empty && !refill_valid;
   assign pop       = deq_valid && deq_ready && !flush;

   snoop_meta_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .push   (push),
      .pop    (pop),
      .wr_idx (wr_idx),
      .rd_idx (rd_idx),
      .live   (live),
      .full   (full),
      .empty  (empty)
   );

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic load_e;
      assign load_e = push && (wr_idx == AW'(e));
      for (genvar l = 0; l < LINES; l++) begin : g_line
         snoop_meta_line #(
            .SET_W(SET_W),
            .WAY_W(WAY_W),
            .TAG_W(TAG_W)
         ) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .live     (live[e]),
            .load     (load_e),
            .ld_set   (enq_set[l*SET_W +: SET_W]),
            .ld_way   (enq_way[l*WAY_W +: WAY_W]),
            .ld_tag   (enq_tag[l*TAG_W +: TAG_W]),
            .ld_hit   (enq_hit[l]),
            .rf_valid (refill_valid),
            .rf_set   (refill_set),
            .rf_way   (refill_way),
            .rf_tag   (refill_tag),
            .set_q    (set_a[e][l]),
            .way_q    (way_a[e][l]),
            .tag_q    (tag_a[e][l]),
            .hit_q    (hit_a[e][l])
         );
      end
   end

   for (genvar l = 0; l < LINES; l++) begin : g_head
      always_comb begin
         deq_set[l*SET_W +: SET_W] = set_a[0][l];
         deq_way[l*WAY_W +: WAY_W] = way_a[0][l];
         deq_tag[l*TAG_W +: TAG_W] = tag_a[0][l];
         deq_hit[l]                = hit_a[0][l];
         for (int e = 1; e < DEPTH; e++) begin
            if (rd_idx == AW'(e)) begin
               deq_set[l*SET_W +: SET_W] = set_a[e][l];
               deq_way[l*WAY_W +: WAY_W] = way_a[e][l];
               deq_tag[l*TAG_W +: TAG_W] = tag_a[e][l];
               deq_hit[l]                = hit_a[e][l];
            end
         end
      end
   end

   // R8
   refill_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid && !flush) |=> ($stable(empty) && $stable(full)));

   // R9
   refill_no_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid && empty && !flush) |=> empty);

   // R4
   empty_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !deq_valid);

   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !deq_valid));

endmodule

// File: tb/snoop_meta_fifo_bench.sv
`timescale 1ns/1ps
module snoop_meta_fifo_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        enq_valid = 1'b0;
   logic [11:0] enq_set = '0;
   logic [3:0]  enq_way = '0;
   logic [39:0] enq_tag = '0;
   logic [1:0]  enq_hit = '0;
   logic        full, empty;
   logic        deq_ready = 1'b0;
   logic        deq_valid;
   logic [11:0] deq_set;
   logic [3:0]  deq_way;
   logic [39:0] deq_tag;
   logic [1:0]  deq_hit;
   logic        refill_valid = 1'b0;
   logic [5:0]  refill_set = '0;
   logic [1:0]  refill_way = '0;
   logic [19:0] refill_tag = '0;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   snoop_meta_fifo u_snoop_meta_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .enq_valid(enq_valid), .enq_set(enq_set), .enq_way(enq_way),
      .enq_tag(enq_tag), .enq_hit(enq_hit),
      .full(full), .empty(empty),
      .deq_ready(deq_ready), .deq_valid(deq_valid),
      .deq_set(deq_set), .deq_way(deq_way), .deq_tag(deq_tag), .deq_hit(deq_hit),
      .refill_valid(refill_valid), .refill_set(refill_set),
      .refill_way(refill_way), .refill_tag(refill_tag)
   );

   typedef struct packed {
      logic [5:0]  s0; logic [1:0] w0; logic [19:0] t0; logic h0;
      logic [5:0]  s1; logic [1:0] w1; logic [19:0] t1; logic h1;
      logic [5:0]  rs; logic [1:0] rw; logic [19:0] rt;
      logic        eh0; logic [1:0] ew0; logic eh1; logic [1:0] ew1;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      // miss filled in line 0, line 1 in another set untouched
      '{6'd5,  2'd0, 20'h00123, 1'b0, 6'd9,  2'd1, 20'h00222, 1'b0,
        6'd5,  2'd3, 20'h00123, 1'b1, 2'd3, 1'b0, 2'd1},
      // hit evicted in line 0, hit in another way of same set kept
      '{6'd7,  2'd2, 20'h00AAA, 1'b1, 6'd7,  2'd1, 20'h00BBB, 1'b1,
        6'd7,  2'd2, 20'h00CCC, 1'b0, 2'd2, 1'b1, 2'd1},
      // one refill evicts line 0 and fills line 1
      '{6'd3,  2'd1, 20'h00010, 1'b1, 6'd3,  2'd0, 20'h00020, 1'b0,
        6'd3,  2'd1, 20'h00020, 1'b0, 2'd1, 1'b1, 2'd1},
      // same tag rewritten over a hit, other-set miss untouched
      '{6'd4,  2'd0, 20'h00055, 1'b1, 6'd8,  2'd0, 20'h00055, 1'b0,
        6'd4,  2'd0, 20'h00055, 1'b1, 2'd0, 1'b0, 2'd0},
      // miss in other set kept, hit in refilled set/way evicted
      '{6'd1,  2'd2, 20'h00077, 1'b0, 6'd2,  2'd2, 20'h00066, 1'b1,
        6'd2,  2'd2, 20'h00077, 1'b0, 2'd2, 1'b0, 2'd2},
      // both misses filled by one refill at the field extremes
      '{6'd63, 2'd3, 20'hFFFFF, 1'b0, 6'd63, 2'd0, 20'hFFFFF, 1'b0,
        6'd63, 2'd1, 20'hFFFFF, 1'b1, 2'd1, 1'b1, 2'd1}
   };

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_inputs();
      enq_valid = 1'b0; deq_ready = 1'b0; refill_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic put(input logic [19:0] t0, input logic [19:0] t1);
      enq_valid = 1'b1;
      enq_set = {6'd11, 6'd10};
      enq_way = {2'd1, 2'd0};
      enq_tag = {t1, t0};
      enq_hit = 2'b01;
      tick();
      enq_valid = 1'b0;
   endtask

   logic done = 1'b0;

   initial begin
      #(200000 * 4);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      tick(); tick();
      // R1 reset state
      chk("R1", "empty", 64'(empty), 64'd1);
      chk("R1", "full", 64'(full), 64'd0);
      chk("R1", "deq_valid", 64'(deq_valid), 64'd0);
      rst_n = 1'b1;
      tick();

      // Vector walk: load, one refill cycle, then drain and compare
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VECS[i];
         enq_valid = 1'b1;
         enq_set = {v.s1, v.s0};
         enq_way = {v.w1, v.w0};
         enq_tag = {v.t1, v.t0};
         enq_hit = {v.h1, v.h0};
         tick();
         enq_valid = 1'b0;
         refill_valid = 1'b1;
         refill_set = v.rs; refill_way = v.rw; refill_tag = v.rt;
         deq_ready = 1'b1;
         #1;
         chk("R8", "deq_valid during refill", 64'(deq_valid), 64'd0);
         tick();
         refill_valid = 1'b0;
         #1;
         chk("R8", "entry kept through refill", 64'(deq_valid), 64'd1);
         chk("R5", "line0 hit", 64'(deq_hit[0]), 64'(v.eh0));
         chk("R6", "line0 way", 64'(deq_way[1:0]), 64'(v.ew0));
         chk("R11", "line1 hit", 64'(deq_hit[1]), 64'(v.eh1));
         chk("R7", "line1 way", 64'(deq_way[3:2]), 64'(v.ew1));
         chk("R2", "line0 tag", 64'(deq_tag[19:0]), 64'(v.t0));
         chk("R2", "line1 set", 64'(deq_set[11:6]), 64'(v.s1));
         tick();
         deq_ready = 1'b0;
         chk("R4", "empty after drain", 64'(empty), 64'd1);
      end

      // R3 fill to depth, overflow dropped, R2 order on drain
      for (int k = 0; k < 8; k++) put(20'(k + 16), 20'(k + 256));
      chk("R3", "full after 8", 64'(full), 64'd1);
      put(20'h99999, 20'h99999);
      chk("R3", "full kept", 64'(full), 64'd1);
      deq_ready = 1'b1;
      for (int k = 0; k < 8; k++) begin
         chk("R2", "order line0 tag", 64'(deq_tag[19:0]), 64'(k + 16));
         chk("R2", "order line1 tag", 64'(deq_tag[39:20]), 64'(k + 256));
         tick();
      end
      deq_ready = 1'b0;
      chk("R3", "overflow entry absent", 64'(empty), 64'd1);
      chk("R4", "deq_valid when empty", 64'(deq_valid), 64'd0);

      // R9 enqueue during a non-matching refill is dropped
      enq_valid = 1'b1;
      enq_tag = {20'h00001, 20'h00002};
      refill_valid = 1'b1;
      refill_set = 6'd33; refill_way = 2'd3; refill_tag = 20'h0ABCD;
      tick();
      idle_inputs();
      #1;
      chk("R9", "empty after blocked enq", 64'(empty), 64'd1);
      chk("R9", "deq_valid after blocked enq", 64'(deq_valid), 64'd0);

      // R10 flush clears, same-cycle enqueue dropped, pointers restart
      put(20'h00A01, 20'h00B01);
      put(20'h00A02, 20'h00B02);
      put(20'h00A03, 20'h00B03);
      flush = 1'b1;
      enq_valid = 1'b1;
      tick();
      idle_inputs();
      #1;
      chk("R10", "empty after flush", 64'(empty), 64'd1);
      chk("R10", "deq_valid after flush", 64'(deq_valid), 64'd0);
      put(20'h00C01, 20'h00D01);
      chk("R10", "first after flush", 64'(deq_tag[19:0]), 64'h00C01);
      deq_ready = 1'b1;
      tick();
      deq_ready = 1'b0;
      chk("R10", "empty after single drain", 64'(empty), 64'd1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule